// File: doc/BRIEF.md
# Multi-channel voltage limit monitor

The block takes a stream of 8-bit voltage codes, one channel per sample, each marked by a channel index and a valid strobe. Each code is an unsigned value in which one step stands for 8 mV, so the full scale is 0 to 2.040 V. Every accepted code is kept as that channel's latest reading. The code is also compared with the channel's own low and high limits. A reading outside the window sets a sticky alarm bit for that channel.

Software uses one small register port for all access. Through it, software writes the limits, reads back the readings, limits and alarms, and clears alarms by writing ones. The two lowest bits of each limit are always zero. Limits therefore move in 32 mV steps, while readings keep their full 8 mV resolution.

There are nine channels by default. A build option adds two more, for eleven in total. On some channels the code is half the real voltage. That scaling, the converter and any dividers sit outside the block, which compares raw codes only.

Top module: `vlimit_monitor`

## Requirements
- R1: After reset, every reading is 0x00, every low limit is 0x00, every high limit is 0xFC, and every alarm bit is 0.
- R2: A register address is {region[1:0], chan[3:0]}, with region 0 for reading, 1 for low limit, 2 for high limit and 3 for alarm. A limit write stores the written value with bits [1:0] forced to 0, and the stored limit reads back the same way.
- R3: A sample with smp_valid high and a channel index below the channel count is stored as that channel's reading. It is visible on the next cycle.
- R4: A sample strictly below its channel's low limit sets that channel's alarm bit.
- R5: A sample strictly above its channel's high limit sets that channel's alarm bit.
- R6: A sample equal to either limit, or between the two limits, leaves a clear alarm bit clear.
- R7: Once set, an alarm bit stays set through later in-range samples until software clears it.
- R8: In the alarm region, the chan field selects an alarm byte: byte 0 holds channels 0 to 7 and byte 1 holds channels 8 to 15. Writing a 1 to a bit clears that alarm, and writing a 0 leaves it unchanged. If an out-of-range sample arrives in the same cycle as the clear, the alarm ends up set.
- R9: A sample whose channel index is at or above the channel count changes no reading and no alarm.
- R10: The channel count is 9, or 11 with the extra-channel option. Alarm bits, readings and limits of channels that do not exist read as 0, and writes to them have no effect.
- R11: Comparisons use the stored, truncated limit. For example, a high limit written as 0x83 acts as 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 4 | Channel index of the sample |
| smp_code | input | 8 | Voltage code, 8 mV per step |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address {region, chan} |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |

## Verification
The window compare is tried on each side of both limits. It uses codes exactly on a limit, one step inside and one step outside, and zero and full-scale codes against the default limits. This separates a strict compare from one that includes the limit. Limits are written with nonzero low bits, and codes are placed between the written and the truncated value, so a design that compares against the unmasked limit gives a different result. Out-of-range channel indices, partial clear masks, and a clear that collides with a new alarm show whether bits are ignored, sticky, and set in preference to clear.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
  localparam int VM_DW      = 8;
  localparam int LIM_DROP   = 2;
  localparam logic [VM_DW-1:0] LIM_RST_LO = 8'h00;
  localparam logic [VM_DW-1:0] LIM_RST_HI = 8'hFC;

  typedef enum logic [1:0] {
    RG_READ  = 2'd0,
    RG_LOW   = 2'd1,
    RG_HIGH  = 2'd2,
    RG_ALARM = 2'd3
  } vmon_region_e;

  // Drop the unused low bits of a limit.
  function automatic logic [VM_DW-1:0] lim_quantize(input logic [VM_DW-1:0] v);
    return {v[VM_DW-1:LIM_DROP], {LIM_DROP{1'b0}}};
  endfunction

  // Strict window test: equality with a limit is in range.
  function automatic logic out_of_range(input logic [VM_DW-1:0] s,
                                        input logic [VM_DW-1:0] lo,
                                        input logic [VM_DW-1:0] hi);
    return (s < lo) || (s > hi);
  endfunction
endpackage

// File: rtl/vmon_limit_bank.sv
module vmon_limit_bank #(
  parameter int NCH    = 9,
  parameter int CHAN_W = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_lo,
  input  logic                                 wr_hi,
  input  logic [CHAN_W-1:0]                    wr_chan,
  input  logic [vmon_pkg::VM_DW-1:0]           wdata,
  output logic [NCH-1:0][vmon_pkg::VM_DW-1:0]  lo_q,
  output logic [NCH-1:0][vmon_pkg::VM_DW-1:0]  hi_q
);
  import vmon_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        lo_q[c] <= LIM_RST_LO;
        hi_q[c] <= LIM_RST_HI;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_lo && wr_chan == CHAN_W'(c)) lo_q[c] <= lim_quantize(wdata);
        if (wr_hi && wr_chan == CHAN_W'(c)) hi_q[c] <= lim_quantize(wdata);
      end
    end
  end

  // R2
  lo_write_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && wr_chan == '0) |=>
      (lo_q[0][LIM_DROP-1:0] == '0) &&
      (lo_q[0][VM_DW-1:LIM_DROP] == $past(wdata[VM_DW-1:LIM_DROP])));

  // R2
  hi_write_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && wr_chan == '0) |=>
      (hi_q[0][LIM_DROP-1:0] == '0) &&
      (hi_q[0][VM_DW-1:LIM_DROP] == $past(wdata[VM_DW-1:LIM_DROP])));
endmodule

// File: rtl/vmon_chan_cell.sv
module vmon_chan_cell (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hit,
  input  logic [vmon_pkg::VM_DW-1:0]  sample,
  input  logic [vmon_pkg::VM_DW-1:0]  lo_lim,
  input  logic [vmon_pkg::VM_DW-1:0]  hi_lim,
  input  logic                        clr,
  output logic [vmon_pkg::VM_DW-1:0]  reading,
  output logic                        alarm,
  output logic                        set_evt
);
  import vmon_pkg::*;

  assign set_evt = hit && out_of_range(sample, lo_lim, hi_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reading <= '0;
      alarm   <= 1'b0;
    end else begin
      if (hit) reading <= sample;
      if (set_evt)  alarm <= 1'b1;
      else if (clr) alarm <= 1'b0;
    end
  end

  // R3
  reading_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> reading == $past(sample));

  // R4
  below_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sample < lo_lim) |=> alarm);

  // R5
  above_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sample > hi_lim) |=> alarm);

  // R6
  in_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sample >= lo_lim && sample <= hi_lim && !alarm) |=> !alarm);

  // R7
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr) |=> alarm);

  // R8
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !alarm);
endmodule

// File: rtl/vlimit_monitor.sv
module vlimit_monitor #(
  parameter int BASE_CH  = 9,
  parameter bit WITH_AUX = 1'b0,
  parameter int CHAN_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic [CHAN_W-1:0]          smp_chan,
  input  logic [vmon_pkg::VM_DW-1:0] smp_code,
  input  logic                       reg_wr,
  input  logic [CHAN_W+1:0]          reg_addr,
  input  logic [vmon_pkg::VM_DW-1:0] reg_wdata,
  output logic [vmon_pkg::VM_DW-1:0] reg_rdata
);
  import vmon_pkg::*;

  localparam int NCH       = BASE_CH + (WITH_AUX ? 2 : 0);
  localparam int ALM_W     = 1 << CHAN_W;
  localparam int ALM_BYTES = ALM_W / VM_DW;
  localparam logic [CHAN_W:0] NCH_L   = (CHAN_W+1)'(NCH);
  localparam logic [CHAN_W:0] BYTES_L = (CHAN_W+1)'(ALM_BYTES);

  vmon_region_e            region;
  logic [CHAN_W-1:0]       rchan;
  logic                    rsel_ok;
  logic                    bsel_ok;
  logic                    chan_ok;
  logic                    alarm_wr;

  logic [NCH-1:0][VM_DW-1:0] lo_q, hi_q, reading_q;
  logic [NCH-1:0]            alarm_vec, hit_vec, clr_vec, set_vec;
  logic [ALM_W-1:0]          alm_pad;

  assign region   = vmon_region_e'(reg_addr[CHAN_W+1:CHAN_W]);
  assign rchan    = reg_addr[CHAN_W-1:0];
  assign rsel_ok  = {1'b0, rchan} < NCH_L;
  assign bsel_ok  = {1'b0, rchan} < BYTES_L;
  assign chan_ok  = {1'b0, smp_chan} < NCH_L;
  assign alarm_wr = reg_wr && (region == RG_ALARM) && bsel_ok;

  vmon_limit_bank #(.NCH(NCH), .CHAN_W(CHAN_W)) u_limits (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (reg_wr && region == RG_LOW  && rsel_ok),
    .wr_hi   (reg_wr && region == RG_HIGH && rsel_ok),
    .wr_chan (rchan),
    .wdata   (reg_wdata),
    .lo_q    (lo_q),
    .hi_q    (hi_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign hit_vec[c] = smp_valid && (smp_chan == CHAN_W'(c));
    assign clr_vec[c] = alarm_wr && (rchan == CHAN_W'(c / VM_DW)) &&
                        reg_wdata[c % VM_DW];
    vmon_chan_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit_vec[c]),
      .sample  (smp_code),
      .lo_lim  (lo_q[c]),
      .hi_lim  (hi_q[c]),
      .clr     (clr_vec[c]),
      .reading (reading_q[c]),
      .alarm   (alarm_vec[c]),
      .set_evt (set_vec[c])
    );
  end

  if (ALM_W > NCH) begin : g_pad
    assign alm_pad = {{(ALM_W-NCH){1'b0}}, alarm_vec};
  end else begin : g_nopad
    assign alm_pad = alarm_vec;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (region)
      RG_READ:  if (rsel_ok) reg_rdata = reading_q[rchan];
      RG_LOW:   if (rsel_ok) reg_rdata = lo_q[rchan];
      RG_HIGH:  if (rsel_ok) reg_rdata = hi_q[rchan];
      RG_ALARM: if (bsel_ok) reg_rdata = alm_pad[int'(rchan)*VM_DW +: VM_DW];
      default:  reg_rdata = '0;
    endcase
  end

  // R9
  stray_chan_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !chan_ok && !alarm_wr) |=>
      $stable(alarm_vec) && $stable(reading_q));

  // R2
  limit_readback_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_LOW || region == RG_HIGH) |-> reg_rdata[LIM_DROP-1:0] == '0);

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & clr_vec)) |=> |alarm_vec);
endmodule

// File: tb/vlimit_monitor_tb.sv
module vlimit_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_valid;
  logic [3:0] smp_chan;
  logic [7:0] smp_code;
  logic       reg_wr;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vlimit_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_code(smp_code), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  localparam logic [1:0] RD = 2'd0, LO = 2'd1, HI = 2'd2, AL = 2'd3;

  // {chan[3:0], code[7:0], expected alarm}
  localparam logic [12:0] VEC [12] = '{
    {4'd1, 8'h40, 1'b0}, {4'd1, 8'h80, 1'b0}, {4'd1, 8'h3F, 1'b1},
    {4'd1, 8'h81, 1'b1}, {4'd1, 8'h60, 1'b0}, {4'd2, 8'h20, 1'b0},
    {4'd2, 8'h22, 1'b0}, {4'd2, 8'h1F, 1'b1}, {4'd0, 8'hFC, 1'b0},
    {4'd0, 8'hFD, 1'b1}, {4'd8, 8'h00, 1'b0}, {4'd8, 8'hFF, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] rg, input logic [3:0] ch, output logic [7:0] v);
    reg_addr = {rg, ch};
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] rg, input logic [3:0] ch, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {rg, ch}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic sample(input logic [3:0] ch, input logic [7:0] code);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_code = code;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clear_all();
    wr(AL, 4'd0, 8'hFF);
    wr(AL, 4'd1, 8'hFF);
  endtask

  initial begin
    for (int i = 0; i < 10000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_code = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 9; c++) begin
      rd(RD, 4'(c), v); chk("R1 reading", v, 8'h00);
      rd(LO, 4'(c), v); chk("R1 low", v, 8'h00);
      rd(HI, 4'(c), v); chk("R1 high", v, 8'hFC);
    end
    rd(AL, 4'd0, v); chk("R1 alarm0", v, 8'h00);
    rd(AL, 4'd1, v); chk("R1 alarm1", v, 8'h00);

    // R2 limit truncation
    wr(LO, 4'd1, 8'h41); wr(HI, 4'd1, 8'h83); wr(LO, 4'd2, 8'h23);
    rd(LO, 4'd1, v); chk("R2 lo1", v, 8'h40);
    rd(HI, 4'd1, v); chk("R2 hi1", v, 8'h80);
    rd(LO, 4'd2, v); chk("R2 lo2", v, 8'h20);

    // R3 R4 R5 R6 R11 table walk
    for (int i = 0; i < 12; i++) begin
      logic [3:0] ch;
      logic [7:0] code;
      logic       ea;
      {ch, code, ea} = VEC[i];
      clear_all();
      sample(ch, code);
      rd(RD, ch, v); chk("R3 reading", v, code);
      rd(AL, 4'(ch / 8), v);
      chk("R4/R5/R6/R11 alarm", {7'd0, v[ch % 8]}, {7'd0, ea});
    end

    // R7 sticky
    clear_all();
    sample(4'd1, 8'h10);
    sample(4'd1, 8'h60);
    rd(AL, 4'd0, v); chk("R7 sticky", v, 8'h02);
    rd(RD, 4'd1, v); chk("R7 reading", v, 8'h60);

    // R8 selective clear
    sample(4'd2, 8'h00);
    rd(AL, 4'd0, v); chk("R8 two set", v, 8'h06);
    wr(AL, 4'd0, 8'h02);
    rd(AL, 4'd0, v); chk("R8 partial clear", v, 8'h04);

    // R8 set wins over clear in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {AL, 4'd0}; reg_wdata = 8'hFF;
    smp_valid = 1'b1; smp_chan = 4'd2; smp_code = 8'h00;
    @(negedge clk);
    reg_wr = 1'b0; smp_valid = 1'b0;
    rd(AL, 4'd0, v); chk("R8 set wins", v, 8'h04);

    // R9 out-of-range channel ignored
    clear_all();
    sample(4'd9, 8'hFF);
    sample(4'd15, 8'h00);
    rd(AL, 4'd0, v); chk("R9 alarm0", v, 8'h00);
    rd(AL, 4'd1, v); chk("R9 alarm1", v, 8'h00);
    rd(RD, 4'd0, v); chk("R9 reading0", v, 8'hFD);
    rd(RD, 4'd8, v); chk("R9 reading8", v, 8'hFF);
    rd(RD, 4'd2, v); chk("R9 reading2", v, 8'h00);

    // R10 absent channels
    rd(RD, 4'd9, v); chk("R10 reading9", v, 8'h00);
    wr(LO, 4'd9, 8'h80);
    rd(LO, 4'd9, v); chk("R10 low9", v, 8'h00);
    sample(4'd8, 8'hFF);
    rd(AL, 4'd1, v); chk("R10 alarm1 width", v, 8'h01);
    rd(AL, 4'd2, v); chk("R10 alarm2", v, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule